// File: doc/BRIEF.md
# Slow-Clock Timer with Synchronized Register Writes

This block is an 8-bit counter that advances on a slow timer clock (nominally 32 kHz) with no fixed phase relation to the system clock. A processor on the fast system clock loads three registers: the count, the compare value and a control register. Each write is held in a staging register on the system side. A toggle handshake then carries it into the timer domain. The register's own busy bit stays high until the timer domain has applied the value and the acknowledge has returned. A write that arrives while that register's busy bit is high is dropped.

The timer domain detects two events: overflow (255 wrapping to 0) and compare match. It also toggles a compare output pin. Both events pass back through a synchronizer and set sticky interrupt flags on the system side. Software clears those flags by writing 1. The system side also keeps a synchronized copy of the count for reads.

The write port is a plain strobe (`wr_en`). There is no ready signal and no back-pressure. Software must poll `busy` before it writes again to the same register. Writes to different registers may overlap.

Top module: `slowclk_timer`

## Requirements
- R1: `wr_sel` chooses the target register: 0 is the count, 1 is the compare value, 2 is the control register. When `wr_en` is high and `busy[wr_sel]` is low, the write is accepted. `busy[wr_sel]` is high from the next system cycle until the value has been applied in the timer domain and the acknowledge has been seen.
- R2: A busy bit rises only after an accepted write to its own register. A write with `wr_sel` = 3 changes nothing.
- R3: A write to a register whose busy bit is high is ignored. The pending value is the one that takes effect.
- R4: When control bit 0 is 1, the count advances by one on every timer clock. When it is 0, the count holds, and writes to the count still complete and take effect.
- R5: When the count wraps from 255 to 0 by incrementing, an overflow event occurs and sets `irq_flags[0]`.
- R6: When counting is enabled and the count equals the compare value, a compare event occurs and sets `irq_flags[1]`.
- R7: No compare event occurs while a count or compare write is in transfer inside the timer domain.
- R8: `cmp_pin` resets to 0 and toggles on each compare event, on the timer clock, with no resynchronization.
- R9: A flag rises one timer cycle plus three system cycles after its event. `cnt_rd` updates in step with the flags, so at the moment a flag rises it already shows a count at least one past the count that caused the event.
- R10: Writing 1 to a bit of `flag_clr` clears that flag and leaves the other flag alone. If a flag is set and cleared in the same cycle, the set wins.
- R11: After reset, `busy` is 0, `irq_flags` is 0, `cnt_rd` is 0, `cmp_pin` is 0 and counting is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System (processor) clock |
| sys_rst_n | input | 1 | Active-low asynchronous reset, system domain |
| tmr_clk | input | 1 | Slow timer clock |
| tmr_rst_n | input | 1 | Active-low asynchronous reset, timer domain |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Target register: 0 count, 1 compare, 2 control |
| wr_data | input | CNT_W | Write value; for the control register only bit 0 (count enable) is used |
| flag_clr | input | 2 | Write-1-to-clear for the interrupt flags |
| busy | output | 3 | Per-register update-busy bits, indexed like `wr_sel` |
| irq_flags | output | 2 | Bit 0 overflow, bit 1 compare |
| cnt_rd | output | CNT_W | Synchronized copy of the count |
| cmp_pin | output | 1 | Compare output, toggled in the timer domain |

## Verification
If the handshake toggles are out of step, a busy bit stays high indefinitely or never rises. The bench sees this on the cycle after a write, or when its bounded wait for idle expires, which is a few timer periods. A wrong compare-suppression window shows up in two ways. Either a compare flag appears while a count write races past the compare value, or the flag never appears on the planned match. In both cases `cnt_rd` makes the discrepancy visible within a handful of timer periods. An error in the flag synchronizer depth or in the count copy shows up as a count outside the expected one-past window at the cycle the flag rises.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    SEL_CNT  = 2'd0,
    SEL_CMP  = 2'd1,
    SEL_CTL  = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  localparam int EV_OVF = 0;
  localparam int EV_CMP = 1;
  localparam int NUM_EV = 2;
  localparam int NUM_REG = 3;
endpackage

// File: rtl/tmr_wr_xfer.sv
// One register write crossing: staging register and request toggle on the
// system side, three-flop request synchronizer and acknowledge on the timer side.
module tmr_wr_xfer #(
  parameter int W = 8
) (
  input  logic         sys_clk,
  input  logic         sys_rst_n,
  input  logic         tmr_clk,
  input  logic         tmr_rst_n,
  input  logic         wr_go,
  input  logic [W-1:0] wr_data,
  output logic         busy,
  output logic         ld,
  output logic [W-1:0] ld_data,
  output logic         pend
);
  logic         req_tgl;
  logic [W-1:0] stage_q;
  logic [1:0]   ack_sync;
  logic [2:0]   req_sync;

  // system side: accept only when idle
  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      req_tgl <= 1'b0;
      stage_q <= '0;
    end else if (wr_go && !busy) begin
      req_tgl <= ~req_tgl;
      stage_q <= wr_data;
    end
  end

  // acknowledge is the last request stage, brought back over two flops
  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) ack_sync <= '0;
    else            ack_sync <= {ack_sync[0], req_sync[2]};
  end

  assign busy = req_tgl ^ ack_sync[1];

  // timer side
  always_ff @(posedge tmr_clk or negedge tmr_rst_n) begin
    if (!tmr_rst_n) req_sync <= '0;
    else            req_sync <= {req_sync[1:0], req_tgl};
  end

  assign ld      = req_sync[1] ^ req_sync[2];
  assign pend    = req_sync[0] ^ req_sync[2];
  assign ld_data = stage_q;  // held stable while busy
endmodule

// File: rtl/tmr_core.sv
// Timer-domain counter, compare register, enable bit and event generation.
module tmr_core #(
  parameter int W = 8
) (
  input  logic                      tmr_clk,
  input  logic                      tmr_rst_n,
  input  logic                      ld_cnt,
  input  logic [W-1:0]              cnt_d,
  input  logic                      ld_cmp,
  input  logic [W-1:0]              cmp_d,
  input  logic                      ld_ctl,
  input  logic                      ctl_d,
  input  logic                      cmp_block,
  output logic [W-1:0]              count,
  output logic [tmr_pkg::NUM_EV-1:0] ev_tgl,
  output logic                      snap_tgl,
  output logic                      cmp_pin,
  output logic                      ovf_evt,
  output logic                      cmp_evt
);
  import tmr_pkg::*;

  localparam logic [W-1:0] CNT_MAX = '1;

  logic         en;
  logic [W-1:0] ocr;
  logic         tick;

  assign tick    = en && !ld_cnt;
  assign ovf_evt = tick && (count == CNT_MAX);
  assign cmp_evt = tick && (count == ocr) && !cmp_block;

  always_ff @(posedge tmr_clk or negedge tmr_rst_n) begin
    if (!tmr_rst_n) begin
      count    <= '0;
      ocr      <= '0;
      en       <= 1'b0;
      ev_tgl   <= '0;
      snap_tgl <= 1'b0;
      cmp_pin  <= 1'b0;
    end else begin
      if (ld_cnt)    count <= cnt_d;
      else if (tick) count <= count + 1'b1;
      if (ld_cmp) ocr <= cmp_d;
      if (ld_ctl) en  <= ctl_d;
      ev_tgl[EV_OVF] <= ev_tgl[EV_OVF] ^ ovf_evt;
      ev_tgl[EV_CMP] <= ev_tgl[EV_CMP] ^ cmp_evt;
      cmp_pin        <= cmp_pin ^ cmp_evt;
      snap_tgl       <= ~snap_tgl;
    end
  end
endmodule

// File: rtl/tmr_sys_sync.sv
// System-side event flags and count copy, each fed by a three-flop toggle synchronizer.
module tmr_sys_sync #(
  parameter int W = 8,
  parameter int N = 2
) (
  input  logic         sys_clk,
  input  logic         sys_rst_n,
  input  logic [N-1:0] ev_tgl,
  input  logic [N-1:0] flag_clr,
  input  logic         snap_tgl,
  input  logic [W-1:0] count_in,
  output logic [N-1:0] flags,
  output logic [W-1:0] count_rd
);
  for (genvar g = 0; g < N; g++) begin : g_ev
    logic [2:0] s;
    logic       f;
    always_ff @(posedge sys_clk or negedge sys_rst_n) begin
      if (!sys_rst_n) begin
        s <= '0;
        f <= 1'b0;
      end else begin
        s <= {s[1:0], ev_tgl[g]};
        f <= (f & ~flag_clr[g]) | (s[1] ^ s[2]);
      end
    end
    assign flags[g] = f;
  end

  logic [2:0] cs;
  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      cs       <= '0;
      count_rd <= '0;
    end else begin
      cs <= {cs[1:0], snap_tgl};
      if (cs[1] ^ cs[2]) count_rd <= count_in;  // count stable for a full timer cycle
    end
  end
endmodule

// File: rtl/slowclk_timer.sv
module slowclk_timer #(
  parameter int CNT_W = 8
) (
  input  logic             sys_clk,
  input  logic             sys_rst_n,
  input  logic             tmr_clk,
  input  logic             tmr_rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       flag_clr,
  output logic [2:0]       busy,
  output logic [1:0]       irq_flags,
  output logic [CNT_W-1:0] cnt_rd,
  output logic             cmp_pin
);
  import tmr_pkg::*;

  logic             go_cnt, go_cmp, go_ctl;
  logic             ld_cnt, ld_cmp, ld_ctl;
  logic             pend_cnt, pend_cmp, pend_ctl;
  logic [CNT_W-1:0] d_cnt, d_cmp;
  logic             d_ctl;
  logic [CNT_W-1:0] tmr_count;
  logic [NUM_EV-1:0] ev_tgl;
  logic             snap_tgl;
  logic             ovf_evt, cmp_evt;

  assign go_cnt = wr_en && (wr_sel == SEL_CNT);
  assign go_cmp = wr_en && (wr_sel == SEL_CMP);
  assign go_ctl = wr_en && (wr_sel == SEL_CTL);

  tmr_wr_xfer #(.W(CNT_W)) u_x_cnt (
    .sys_clk, .sys_rst_n, .tmr_clk, .tmr_rst_n,
    .wr_go(go_cnt), .wr_data(wr_data), .busy(busy[SEL_CNT]),
    .ld(ld_cnt), .ld_data(d_cnt), .pend(pend_cnt)
  );

  tmr_wr_xfer #(.W(CNT_W)) u_x_cmp (
    .sys_clk, .sys_rst_n, .tmr_clk, .tmr_rst_n,
    .wr_go(go_cmp), .wr_data(wr_data), .busy(busy[SEL_CMP]),
    .ld(ld_cmp), .ld_data(d_cmp), .pend(pend_cmp)
  );

  tmr_wr_xfer #(.W(1)) u_x_ctl (
    .sys_clk, .sys_rst_n, .tmr_clk, .tmr_rst_n,
    .wr_go(go_ctl), .wr_data(wr_data[0]), .busy(busy[SEL_CTL]),
    .ld(ld_ctl), .ld_data(d_ctl), .pend(pend_ctl)
  );

  tmr_core #(.W(CNT_W)) u_core (
    .tmr_clk, .tmr_rst_n,
    .ld_cnt, .cnt_d(d_cnt), .ld_cmp, .cmp_d(d_cmp),
    .ld_ctl, .ctl_d(d_ctl),
    .cmp_block(pend_cnt | pend_cmp),
    .count(tmr_count), .ev_tgl, .snap_tgl, .cmp_pin, .ovf_evt, .cmp_evt
  );

  tmr_sys_sync #(.W(CNT_W), .N(NUM_EV)) u_sync (
    .sys_clk, .sys_rst_n, .ev_tgl, .flag_clr, .snap_tgl,
    .count_in(tmr_count), .flags(irq_flags), .count_rd(cnt_rd)
  );

  // control-write pending does not block compare
  logic unused_pend;
  assign unused_pend = pend_ctl;
endmodule

// File: rtl/slowclk_timer_chk.sv
module slowclk_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             sys_clk,
  input logic             sys_rst_n,
  input logic             tmr_clk,
  input logic             tmr_rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic [2:0]       busy,
  input logic [1:0]       flag_clr,
  input logic [1:0]       irq_flags,
  input logic             cmp_pin,
  input logic             ovf_evt,
  input logic             cmp_evt,
  input logic [CNT_W-1:0] tmr_count
);
  for (genvar k = 0; k < 3; k++) begin : g_busy
    // R1
    busy_sets_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      (wr_en && wr_sel == k && !busy[k]) |=> busy[k]);
    // R2
    busy_cause_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      $rose(busy[k]) |-> $past(wr_en && wr_sel == k));
  end

  for (genvar i = 0; i < 2; i++) begin : g_flag
    // R10
    flag_sticky_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      $fell(irq_flags[i]) |-> $past(flag_clr[i]));
  end

  // R5
  ovf_wrap_chk: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
    ovf_evt |=> (tmr_count == '0));

  // R8
  pin_toggle_chk: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
    !$stable(cmp_pin) |-> $past(cmp_evt));
endmodule

bind slowclk_timer slowclk_timer_chk #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/slowclk_timer_tb_top.sv
module slowclk_timer_tb_top;
  localparam int W = 8;

  logic         sys_clk = 1'b0;
  logic         tmr_clk = 1'b0;
  logic         sys_rst_n = 1'b0;
  logic         tmr_rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_sel = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic [1:0]   flag_clr = 2'b00;
  logic [2:0]   busy;
  logic [1:0]   irq_flags;
  logic [W-1:0] cnt_rd;
  logic         cmp_pin;

  int checks = 0;
  int errors = 0;

  always #2 sys_clk = ~sys_clk;   // 250 MHz
  always #82 tmr_clk = ~tmr_clk;  // slow, unrelated period

  slowclk_timer #(.CNT_W(W)) dut_i (
    .sys_clk, .sys_rst_n, .tmr_clk, .tmr_rst_n, .wr_en, .wr_sel, .wr_data,
    .flag_clr, .busy, .irq_flags, .cnt_rd, .cmp_pin
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] sel, input logic [W-1:0] d);
    @(negedge sys_clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge sys_clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_flags(input logic [1:0] m);
    @(negedge sys_clk);
    flag_clr = m;
    @(negedge sys_clk);
    flag_clr = 2'b00;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (busy != 3'b000 && n < 3000) begin
      @(negedge sys_clk);
      n++;
    end
    chk(busy == 3'b000, req, "busy clears", int'(busy), 0);
  endtask

  task automatic wait_tmr(input int n);
    repeat (n) @(posedge tmr_clk);
    repeat (6) @(negedge sys_clk);
  endtask

  task automatic test_reset();
    chk(busy == 3'b000, "R11", "busy after reset", int'(busy), 0);
    chk(irq_flags == 2'b00, "R11", "flags after reset", int'(irq_flags), 0);
    chk(cnt_rd == 8'h00, "R11", "count after reset", int'(cnt_rd), 0);
    chk(cmp_pin == 1'b0, "R11", "pin after reset", int'(cmp_pin), 0);
    wait_tmr(4);
    chk(cnt_rd == 8'h00, "R11", "count disabled after reset", int'(cnt_rd), 0);
  endtask

  task automatic test_bad_sel();
    write_reg(2'd3, 8'hFF);
    chk(busy == 3'b000, "R2", "select 3 sets no busy", int'(busy), 0);
  endtask

  task automatic test_load_disabled();
    write_reg(2'd0, 8'h40);
    chk(busy == 3'b001, "R1", "count busy after write", int'(busy), 1);
    wait_idle("R1");
    wait_tmr(4);
    chk(cnt_rd == 8'h40, "R4", "count loaded while disabled, held", int'(cnt_rd), 'h40);
  endtask

  task automatic test_ignored_and_match();
    int n = 0;
    write_reg(2'd1, 8'h10);
    write_reg(2'd1, 8'h20);  // busy: must be dropped
    chk(busy[1] == 1'b1, "R3", "compare still busy", int'(busy[1]), 1);
    wait_idle("R3");
    write_reg(2'd0, 8'h0E);
    wait_idle("R4");
    write_reg(2'd2, 8'h01);
    wait_idle("R4");
    while (!irq_flags[1] && n < 20000) begin
      @(negedge sys_clk);
      n++;
    end
    chk(irq_flags[1] == 1'b1, "R6", "compare flag set", int'(irq_flags[1]), 1);
    chk(cnt_rd == 8'h11 || cnt_rd == 8'h12, "R3", "match at first value 0x10, count one past",
        int'(cnt_rd), 'h11);
    chk(cmp_pin == 1'b1, "R8", "pin toggled on match", int'(cmp_pin), 1);
  endtask

  task automatic test_overflow_w1c();
    int n = 0;
    write_reg(2'd0, 8'hFD);
    wait_idle("R1");
    while (!irq_flags[0] && n < 20000) begin
      @(negedge sys_clk);
      n++;
    end
    chk(irq_flags[0] == 1'b1, "R5", "overflow flag set", int'(irq_flags[0]), 1);
    chk(cnt_rd == 8'h00 || cnt_rd == 8'h01, "R9", "count one past wrap at flag", int'(cnt_rd), 0);
    clear_flags(2'b01);
    chk(irq_flags == 2'b10, "R10", "clear overflow only", int'(irq_flags), 2);
    clear_flags(2'b10);
    chk(irq_flags == 2'b00, "R10", "clear compare", int'(irq_flags), 0);
  endtask

  task automatic test_suppress();
    int n = 0;
    write_reg(2'd1, 8'h70);
    wait_idle("R7");
    clear_flags(2'b11);
    while (cnt_rd != 8'h6F && n < 40000) begin
      @(negedge sys_clk);
      n++;
    end
    chk(cnt_rd == 8'h6F, "R7", "reached 0x6F", int'(cnt_rd), 'h6F);
    write_reg(2'd0, 8'h90);
    wait_idle("R7");
    wait_tmr(2);
    chk(irq_flags[1] == 1'b0, "R7", "no compare while count write in flight",
        int'(irq_flags[1]), 0);
    chk(cnt_rd >= 8'h90 && cnt_rd < 8'hA0, "R7", "count took new value", int'(cnt_rd), 'h90);
  endtask

  task automatic test_hold();
    logic [W-1:0] v;
    write_reg(2'd2, 8'h00);
    wait_idle("R4");
    wait_tmr(2);
    v = cnt_rd;
    wait_tmr(5);
    chk(cnt_rd == v, "R4", "count holds when disabled", int'(cnt_rd), int'(v));
    write_reg(2'd0, 8'h22);
    wait_idle("R4");
    wait_tmr(4);
    chk(cnt_rd == 8'h22, "R4", "write completes while disabled", int'(cnt_rd), 'h22);
  endtask

  initial begin
    repeat (200000 - 5000) @(posedge sys_clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(posedge tmr_clk);
    @(negedge sys_clk);
    sys_rst_n = 1'b1;
    tmr_rst_n = 1'b1;
    repeat (4) @(negedge sys_clk);
    test_reset();
    test_bad_sel();
    test_load_disabled();
    test_ignored_and_match();
    test_overflow_w1c();
    test_suppress();
    test_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule